// File: doc/BRIEF.md
# Hashed Page Table Group Address Generator

This block turns one translation request into the two values that a page table walker needs before it reads memory. The first is the physical address of the 64-byte entry group to fetch. The second is the 32-bit word that each entry's first word is compared against. The request carries four things: an effective address, the segment register value that covers it, a table register that holds both the table origin and its size, and a flag that selects the primary or the secondary hash.

The hash combines the virtual segment identifier with the page index and places the result at group granularity. For the secondary probe, the whole shifted hash is complemented. The hash is then limited to the table extent. That extent is always 64 KiB, widened by the table register's size field. The masked hash is merged with the table origin.

Both results are registered. They appear one cycle after a request strobe and stay unchanged until the next strobe.

Top module: `pteg_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `rsp_valid` goes low and both `rsp_grp_addr` and `rsp_cmp_word` become zero.
- R2: `rsp_valid` is high for exactly the one cycle that follows a cycle in which `req_valid` was high; the results belong to the request of that earlier cycle.
- R3: For a primary request, the hash is the segment identifier (`req_seg[27:0]`) XOR the page index (`req_ea[27:12]`), shifted left by 6 and truncated to 32 bits.
- R4: For a secondary request (`req_secondary` = 1), all 32 bits of the shifted hash are inverted before the mask is applied.
- R5: The mask has bits 15:6 set, bits 24:16 copied from `req_tbl[8:0]`, and all other bits clear.
- R6: `rsp_grp_addr` is `req_tbl[31:16]` placed in bits 31:16, ORed with the masked hash; bits 5:0 are always zero.
- R7: `rsp_cmp_word` has bit 31 set. It is ORed with the segment identifier shifted left by 7, with bit 6 equal to `req_secondary`, and with `req_ea[27:22]` in bits 5:0.
- R8: `req_ea[31:28]`, `req_ea[11:0]`, `req_seg[31:28]` and `req_tbl[15:9]` have no effect on either result.
- R9: In a cycle without `req_valid`, both results keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_ea | input | 32 | Effective address |
| req_seg | input | 32 | Segment register value; bits 27:0 are the segment identifier |
| req_tbl | input | 32 | Table register: origin in bits 31:16, size field in bits 8:0 |
| req_secondary | input | 1 | 1 selects the secondary hash |
| rsp_valid | output | 1 | Result strobe |
| rsp_grp_addr | output | 32 | Physical address of the entry group |
| rsp_cmp_word | output | 32 | Word to compare against each entry's first word |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 28-bit segment identifier, a 16-bit page index and a 9-bit size field. With these values the hash can reach bits 33:6 before it is truncated. An all-ones segment identifier therefore shows that truncation, and the fully widened mask (size field 0x1FF) can be tested against the narrowest one (size field 0). They also let a secondary probe spill complemented bits into the size-controlled range, and let ORed origin bits overlap with hash bits.

// File: rtl/pteg_pkg.sv
package pteg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned VSID_W   = 28;
  localparam int unsigned PAGE_W   = 16;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned GRP_LSB  = 6;
  localparam int unsigned BASE_LSB = 16;
  localparam int unsigned SIZE_W   = 9;
  localparam int unsigned API_W    = 6;

  typedef struct packed {
    logic [WORD_W-1:0] grp_addr;
    logic [WORD_W-1:0] cmp_word;
  } pteg_result_t;
endpackage

// File: rtl/pteg_hash.sv
module pteg_hash #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned VSID_W   = 28,
  parameter int unsigned PAGE_W   = 16,
  parameter int unsigned GRP_LSB  = 6,
  parameter int unsigned BASE_LSB = 16,
  parameter int unsigned SIZE_W   = 9
) (
  input  logic [VSID_W-1:0]          vsid,
  input  logic [PAGE_W-1:0]          page,
  input  logic [WORD_W-BASE_LSB-1:0] origin,
  input  logic [SIZE_W-1:0]          size_field,
  input  logic                       secondary,
  output logic [WORD_W-1:0]          grp_addr
);
  localparam logic [WORD_W-1:0] LOW_ONES = (WORD_W'(1) << BASE_LSB) - WORD_W'(1);
  localparam logic [WORD_W-1:0] GRP_ONES = (WORD_W'(1) << GRP_LSB) - WORD_W'(1);
  localparam logic [WORD_W-1:0] FIX_MASK = LOW_ONES & ~GRP_ONES;

  logic [WORD_W-1:0] raw_hash;
  logic [WORD_W-1:0] sel_hash;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] base;

  always_comb begin
    raw_hash = (WORD_W'(vsid) ^ WORD_W'(page)) << GRP_LSB;
    sel_hash = secondary ? ~raw_hash : raw_hash;
    mask     = (WORD_W'(size_field) << BASE_LSB) | FIX_MASK;
    base     = WORD_W'(origin) << BASE_LSB;
    grp_addr = base | (sel_hash & mask);
  end

  always_comb begin
    a_r6_group_aligned : assert ((grp_addr & GRP_ONES) == '0 || $isunknown(grp_addr));
  end
endmodule

// File: rtl/pteg_cmp.sv
module pteg_cmp #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned VSID_W = 28,
  parameter int unsigned API_W  = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              secondary,
  output logic [WORD_W-1:0] cmp_word
);
  localparam int unsigned VSID_POS = API_W + 1;
  localparam logic [WORD_W-1:0] TOP_BIT = WORD_W'(1) << (WORD_W - 1);

  always_comb begin
    cmp_word = TOP_BIT
             | (WORD_W'(vsid) << VSID_POS)
             | (WORD_W'(secondary) << API_W)
             | WORD_W'(api);
  end
endmodule

// File: rtl/pteg_addr_gen.sv
module pteg_addr_gen
  import pteg_pkg::*;
#(
  parameter int unsigned P_WORD_W   = WORD_W,
  parameter int unsigned P_VSID_W   = VSID_W,
  parameter int unsigned P_PAGE_W   = PAGE_W,
  parameter int unsigned P_PAGE_LSB = PAGE_LSB,
  parameter int unsigned P_GRP_LSB  = GRP_LSB,
  parameter int unsigned P_BASE_LSB = BASE_LSB,
  parameter int unsigned P_SIZE_W   = SIZE_W,
  parameter int unsigned P_API_W    = API_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [P_WORD_W-1:0] req_ea,
  input  logic [P_WORD_W-1:0] req_seg,
  input  logic [P_WORD_W-1:0] req_tbl,
  input  logic                req_secondary,
  output logic                rsp_valid,
  output logic [P_WORD_W-1:0] rsp_grp_addr,
  output logic [P_WORD_W-1:0] rsp_cmp_word
);
  localparam int unsigned PAGE_MSB = P_PAGE_LSB + P_PAGE_W - 1;
  localparam int unsigned API_LSB  = PAGE_MSB + 1 - P_API_W;

  logic [P_VSID_W-1:0] vsid;
  logic [P_PAGE_W-1:0] page;
  logic [P_API_W-1:0]  api;
  logic [P_WORD_W-1:0] nxt_addr;
  logic [P_WORD_W-1:0] nxt_cmp;
  logic                unused_bits;

  assign vsid = req_seg[P_VSID_W-1:0];
  assign page = req_ea[PAGE_MSB:P_PAGE_LSB];
  assign api  = req_ea[PAGE_MSB:API_LSB];
  assign unused_bits = ^{req_ea, req_seg, req_tbl};

  pteg_hash #(
    .WORD_W(P_WORD_W), .VSID_W(P_VSID_W), .PAGE_W(P_PAGE_W),
    .GRP_LSB(P_GRP_LSB), .BASE_LSB(P_BASE_LSB), .SIZE_W(P_SIZE_W)
  ) u_hash (
    .vsid       (vsid),
    .page       (page),
    .origin     (req_tbl[P_WORD_W-1:P_BASE_LSB]),
    .size_field (req_tbl[P_SIZE_W-1:0]),
    .secondary  (req_secondary),
    .grp_addr   (nxt_addr)
  );

  pteg_cmp #(
    .WORD_W(P_WORD_W), .VSID_W(P_VSID_W), .API_W(P_API_W)
  ) u_cmp (
    .vsid      (vsid),
    .api       (api),
    .secondary (req_secondary),
    .cmp_word  (nxt_cmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_grp_addr <= '0;
      rsp_cmp_word <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_grp_addr <= nxt_addr;
        rsp_cmp_word <= nxt_cmp;
      end
    end
  end

  a_r2_valid_follows : assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_single_pulse : assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r9_hold : assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_grp_addr) && $stable(rsp_cmp_word)));
  a_r7_secondary_flag : assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_cmp_word[P_API_W] == $past(req_secondary)));
  a_r7_top_bit : assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_cmp_word[P_WORD_W-1]);
endmodule

// File: tb/test_pteg_addr_gen.sv
module test_pteg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [31:0] req_seg = '0;
  logic [31:0] req_tbl = '0;
  logic        req_secondary = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_grp_addr;
  logic [31:0] rsp_cmp_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pteg_addr_gen i_pteg_addr_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
    .req_seg(req_seg), .req_tbl(req_tbl), .req_secondary(req_secondary),
    .rsp_valid(rsp_valid), .rsp_grp_addr(rsp_grp_addr), .rsp_cmp_word(rsp_cmp_word)
  );

  localparam int NV = 10;
  localparam logic [31:0] T_EA  [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_1000,
    32'h0FC0_0000, 32'h0FC0_0000, 32'h0FC0_0000, 32'hF000_0FFF, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000};
  localparam logic [31:0] T_SEG [NV] = '{32'h0, 32'h0, 32'h0, 32'h1, 32'h1, 32'h1,
    32'hF000_0000, 32'h0FFF_FFFF, 32'h0000_0400, 32'h0000_0400};
  localparam logic [31:0] T_TBL [NV] = '{32'h0, 32'h0, 32'h00AB_0000, 32'h1234_0000,
    32'h1234_01FF, 32'h0000_01FF, 32'h0000_FE00, 32'hFFFF_0000, 32'h0000_0001,
    32'h0000_0000};
  localparam logic [NV-1:0] T_SEC = 10'b00_0010_0010;
  localparam logic [31:0] T_ADDR [NV] = '{32'h0000_0000, 32'h0000_FFC0, 32'h00AB_0040,
    32'h1234_0040, 32'h123F_0040, 32'h01C0_FF80, 32'h0000_0000, 32'hFFFF_FFC0,
    32'h0001_0000, 32'h0000_0000};
  localparam logic [31:0] T_CMP [NV] = '{32'h8000_0000, 32'h8000_0040, 32'h8000_0000,
    32'h8000_00BF, 32'h8000_00BF, 32'h8000_00FF, 32'h8000_0000, 32'hFFFF_FF80,
    32'h8002_0000, 32'h8002_0000};
  localparam string T_REQ [NV] = '{"R3", "R4", "R6", "R3", "R5", "R4", "R8", "R7",
    "R5", "R5"};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ea, input logic [31:0] seg,
                       input logic [31:0] tbl, input logic sec);
    @(negedge clk);
    req_ea = ea; req_seg = seg; req_tbl = tbl; req_secondary = sec;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "valid", {31'b0, rsp_valid}, 32'h0);
    check("R1", "addr", rsp_grp_addr, 32'h0);
    check("R1", "cmp", rsp_cmp_word, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(T_EA[i], T_SEG[i], T_TBL[i], T_SEC[i]);
      check("R2", "valid", {31'b0, rsp_valid}, 32'h1);
      check(T_REQ[i], "addr", rsp_grp_addr, T_ADDR[i]);
      check("R7", "cmp", rsp_cmp_word, T_CMP[i]);
    end

    // R2 pulse ends; R9 hold while inputs move without a strobe
    req_ea = 32'h0FFF_FFFF; req_seg = 32'h0ABC_DEF0; req_tbl = 32'hFFFF_FFFF;
    req_secondary = 1'b1;
    @(negedge clk);
    check("R2", "valid drop", {31'b0, rsp_valid}, 32'h0);
    check("R9", "addr hold", rsp_grp_addr, T_ADDR[NV-1]);
    check("R9", "cmp hold", rsp_cmp_word, T_CMP[NV-1]);

    // R2 back-to-back requests each land one cycle later
    @(negedge clk);
    req_ea = 32'h0000_1000; req_seg = 32'h0; req_tbl = 32'h00AB_0000; req_secondary = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    check("R2", "b2b first", rsp_grp_addr, 32'h00AB_0040);
    req_ea = 32'h0; req_tbl = 32'h0; req_secondary = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "b2b second", rsp_grp_addr, 32'h0000_FFC0);
    check("R2", "b2b valid", {31'b0, rsp_valid}, 32'h1);

    // R1 reset in mid-run clears held results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "re-reset addr", rsp_grp_addr, 32'h0);
    check("R1", "re-reset cmp", rsp_cmp_word, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule